// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind a serial-bus slave controller in a byte-wide non-volatile memory model. The controller hands it decoded bus events: start, the loaded address byte, each acknowledged data byte, a strobe for every bit of a byte in flight, and stop. Data bytes are gathered into a page latch of `2**PW` bytes, and a mask records which latch slots hold received data. Only the low `PW` bits of the address counter advance per byte, so a transfer never leaves its page. Bytes past the page end wrap to its start and overwrite what was latched there.

A stop that lands directly after a data byte acknowledge starts the internal write cycle. `busy` rises for exactly `WR_CYCLES` system clocks. During that time the latch is scanned at one slot per clock, and each masked slot is written to the array through the write port. All bus events are ignored while `busy` is high. A stop at any other moment drops the transfer. A write-protect level seen at any point from start to the address byte blocks every data byte of that transfer. The array is RAM that reset fills with `FFh`, and it has a combinational read port.

Top module: `pgwr_buffer`

## Requirements
- R1: After reset, `busy` is 0, `cur_addr` is 0, and every array byte reads `FFh`.
- R2: The address byte loads `cur_addr`. Each data byte then increments only bits `[PW-1:0]` of it, wrapping inside the page, and the upper bits are kept. This also holds for bytes that are rejected.
- R3: One data byte followed by stop writes that byte at the loaded address and changes no other location.
- R4: Several data bytes followed by stop write consecutive locations in the page. The other locations of the page keep their contents.
- R5: With more than `2**PW` bytes, a later byte replaces the earlier byte that was latched at the same wrapped location.
- R6: A stop after a bit strobe of an unfinished data byte writes nothing and leaves `busy` at 0.
- R7: A stop directly after the address byte, with no data bytes, writes nothing and leaves `busy` at 0.
- R8: If `wp_in` is 1 in any cycle from start through the address byte, the transfer writes nothing and raises no `busy`. If `wp_in` is 1 only during the data phase, the write goes ahead.
- R9: `busy` rises in the cycle after the stop edge and stays high for exactly `WR_CYCLES` clocks.
- R10: Start, address, data and stop events during `busy` have no effect on `cur_addr` or on the array.
- R11: At the end of the cycle the valid mask clears and `cur_addr` keeps its last value. Bytes from an earlier transfer are never written again.
- R12: `mem_we` is asserted only while `busy` is high. It writes at most one byte per clock, and every write falls inside the page held in `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_evt | input | 1 | Start or repeated start seen on the bus |
| addr_load | input | 1 | Address byte received and acknowledged |
| addr_in | input | AW | Address carried by `addr_load` |
| data_stb | input | 1 | Data byte received and acknowledged |
| data_in | input | 8 | Byte carried by `data_stb` |
| bit_stb | input | 1 | A bit of the next byte was clocked in |
| stop_evt | input | 1 | Stop seen on the bus |
| wp_in | input | 1 | Write-protect level |
| rd_addr | input | AW | Array read address |
| busy | output | 1 | Internal write cycle running |
| cur_addr | output | AW | Address counter |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 8 | Array write data |
| rd_data | output | 8 | Array read data |

## Verification
The bench builds the block with `AW=7`, `PW=4` and `WR_CYCLES=24`. This gives an array of eight 16-byte pages, small enough that the whole array is compared after every transfer, so a stray write anywhere is caught. The short cycle lets the bench count the `busy` window clock by clock. It also lets the bench inject bus events inside the window and still finish the wrap, overflow and protect cases quickly.

// File: rtl/pgwr_pkg.sv
// Shared types for the page write buffer.
package pgwr_pkg;
    // Transfer phase as seen by the bus-event decoder.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEL  = 2'd1,
        PH_DATA = 2'd2
    } phase_t;
endpackage

// File: rtl/pgwr_ctrl.sv
// Bus-event decoder: tracks the transfer phase, the address counter,
// the write-protect capture and the slot right after a data acknowledge.
// Assumes at most one bus event per clock; ignores everything while busy.
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int AW = 7,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          start_evt,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_in,
    input  logic          data_stb,
    input  logic          bit_stb,
    input  logic          stop_evt,
    input  logic          wp_in,
    input  logic          mask_any,
    output logic [AW-1:0] cur_addr,
    output logic          lat_we,
    output logic [PW-1:0] lat_idx,
    output logic          commit,
    output logic          discard
);
    phase_t        phase;
    logic          wp_lat;
    logic          ack_slot;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_nxt;

    // Next address: only the in-page bits advance.
    always_comb begin
        addr_nxt            = addr_q;
        addr_nxt[PW-1:0]    = addr_q[PW-1:0] + 1'b1;
    end

    // Phase, address, protect and acknowledge-slot tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            wp_lat   <= 1'b0;
            ack_slot <= 1'b0;
            addr_q   <= '0;
        end else if (!busy) begin
            if (stop_evt) begin
                phase    <= PH_IDLE;
                ack_slot <= 1'b0;
            end else if (start_evt) begin
                phase    <= PH_SEL;
                wp_lat   <= wp_in;
                ack_slot <= 1'b0;
            end else if (addr_load && phase == PH_SEL) begin
                addr_q <= addr_in;
                wp_lat <= wp_lat | wp_in;
                phase  <= PH_DATA;
            end else if (phase == PH_SEL) begin
                wp_lat <= wp_lat | wp_in;
            end else if (data_stb && phase == PH_DATA) begin
                addr_q   <= addr_nxt;
                ack_slot <= 1'b1;
            end else if (bit_stb) begin
                ack_slot <= 1'b0;
            end
        end
    end

    // Latch write request for an accepted data byte.
    always_comb begin
        lat_we  = !busy && !stop_evt && !start_evt && phase == PH_DATA
                  && data_stb && !wp_lat;
        lat_idx = addr_q[PW-1:0];
    end

    // Commit on a stop in the acknowledge slot; any other stop or start drops.
    always_comb begin
        commit  = !busy && stop_evt && phase == PH_DATA && ack_slot && mask_any;
        discard = !busy && (stop_evt || start_evt) && !commit;
    end

    assign cur_addr = addr_q;
endmodule

// File: rtl/pgwr_latch.sv
// Page latch: one byte register per page slot plus a valid mask.
// Assumes clear and write are never needed for the same slot in one clock;
// clear wins.
module pgwr_latch #(
    parameter int PW = 4,
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PW-1:0]      widx,
    input  logic [DW-1:0]      wdata,
    input  logic               clr,
    input  logic [PW-1:0]      ridx,
    output logic [DW-1:0]      rdata,
    output logic [(1<<PW)-1:0] mask
);
    localparam int NB = 1 << PW;

    logic [DW-1:0] slot_q [NB];

    // One register per slot, loaded when its index is addressed.
    for (genvar g = 0; g < NB; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (we && widx == PW'(g))
                slot_q[g] <= wdata;
        end
    end

    // Valid mask: set per received byte, cleared on discard or completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (clr)
            mask <= '0;
        else if (we)
            mask[widx] <= 1'b1;
    end

    assign rdata = slot_q[ridx];
endmodule

// File: rtl/pgwr_timer.sv
// Write-cycle timer and commit scanner. On commit it holds busy for
// WR_CYCLES clocks and walks the latch one slot per clock, writing valid
// slots. Assumes WR_CYCLES exceeds the page size so the scan always ends.
module pgwr_timer #(
    parameter int PW        = 4,
    parameter int WR_CYCLES = 250000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [(1<<PW)-1:0] mask,
    output logic               busy,
    output logic               done,
    output logic [PW-1:0]      scan_idx,
    output logic               scan_we
);
    localparam int NB = 1 << PW;
    localparam int TW = $clog2(WR_CYCLES + 1);
    localparam int IW = PW + 1;

    logic [TW-1:0] tcnt;
    logic [IW-1:0] sidx;
    logic          scanning;

    // Cycle counter and scan pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            tcnt <= '0;
            sidx <= '0;
        end else if (commit) begin
            busy <= 1'b1;
            tcnt <= '0;
            sidx <= '0;
        end else if (busy) begin
            tcnt <= tcnt + 1'b1;
            if (scanning)
                sidx <= sidx + 1'b1;
            if (done)
                busy <= 1'b0;
        end
    end

    // Scan decode and end-of-cycle flag.
    always_comb begin
        scanning = busy && (sidx < IW'(NB));
        scan_idx = sidx[PW-1:0];
        scan_we  = scanning && mask[sidx[PW-1:0]];
        done     = busy && (tcnt == TW'(WR_CYCLES - 1));
    end
endmodule

// File: rtl/pgwr_array.sv
// Byte array model with one write port and a combinational read port.
// Reset fills it with all ones, which stands in for an erased array.
module pgwr_array #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Erase on reset, otherwise write one byte when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pgwr_buffer.sv
// Page write buffer top: decoder, page latch, cycle timer and array.
// Assumes AW > PW and WR_CYCLES > 2**PW.
module pgwr_buffer #(
    parameter int AW        = 7,
    parameter int PW        = 4,
    parameter int WR_CYCLES = 250000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_evt,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_in,
    input  logic          data_stb,
    input  logic [7:0]    data_in,
    input  logic          bit_stb,
    input  logic          stop_evt,
    input  logic          wp_in,
    input  logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic [AW-1:0] cur_addr,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [7:0]    rd_data
);
    localparam int NB = 1 << PW;

    logic          lat_we;
    logic [PW-1:0] lat_idx;
    logic          commit;
    logic          discard;
    logic          done;
    logic [PW-1:0] scan_idx;
    logic [NB-1:0] valid_mask;
    logic          mask_any;

    assign mask_any = |valid_mask;

    pgwr_ctrl #(.AW(AW), .PW(PW)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .start_evt(start_evt),
        .addr_load(addr_load),
        .addr_in  (addr_in),
        .data_stb (data_stb),
        .bit_stb  (bit_stb),
        .stop_evt (stop_evt),
        .wp_in    (wp_in),
        .mask_any (mask_any),
        .cur_addr (cur_addr),
        .lat_we   (lat_we),
        .lat_idx  (lat_idx),
        .commit   (commit),
        .discard  (discard)
    );

    pgwr_latch #(.PW(PW), .DW(8)) i_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (lat_we),
        .widx (lat_idx),
        .wdata(data_in),
        .clr  (discard || done),
        .ridx (scan_idx),
        .rdata(mem_wdata),
        .mask (valid_mask)
    );

    pgwr_timer #(.PW(PW), .WR_CYCLES(WR_CYCLES)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .mask    (valid_mask),
        .busy    (busy),
        .done    (done),
        .scan_idx(scan_idx),
        .scan_we (mem_we)
    );

    assign mem_addr = {cur_addr[AW-1:PW], scan_idx};

    pgwr_array #(.AW(AW), .DW(8)) i_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(mem_addr),
        .wdata(mem_wdata),
        .raddr(rd_addr),
        .rdata(rd_data)
    );
endmodule

// File: rtl/pgwr_checker.sv
// Protocol checker for pgwr_buffer, attached by bind.
module pgwr_checker #(
    parameter int AW        = 7,
    parameter int PW        = 4,
    parameter int WR_CYCLES = 250000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               stop_evt,
    input logic               mem_we,
    input logic [AW-1:0]      mem_addr,
    input logic [AW-1:0]      cur_addr,
    input logic [(1<<PW)-1:0] valid_mask
);
    int unsigned run_len;

    // Length of the current busy window so far.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= 0;
        else if (busy)
            run_len <= run_len + 1;
        else
            run_len <= 0;
    end

    assert_we_in_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_we_in_page_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[AW-1:PW] == cur_addr[AW-1:PW]);

    assert_start_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    assert_window_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_len < WR_CYCLES);

    assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_addr));

    assert_mask_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> valid_mask == '0);
endmodule

bind pgwr_buffer pgwr_checker #(.AW(AW), .PW(PW), .WR_CYCLES(WR_CYCLES)) i_pgwr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .stop_evt  (stop_evt),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .cur_addr  (cur_addr),
    .valid_mask(valid_mask)
);

// File: tb/test_pgwr_buffer.sv
// Self-checking bench for pgwr_buffer.
module test_pgwr_buffer;
    localparam int AW  = 7;
    localparam int PW  = 4;
    localparam int WR  = 24;
    localparam int DEP = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_evt = 1'b0, addr_load = 1'b0, data_stb = 1'b0;
    logic          bit_stb = 1'b0, stop_evt = 1'b0, wp_in = 1'b0;
    logic [AW-1:0] addr_in = '0, rd_addr = '0;
    logic [7:0]    data_in = '0;
    logic          busy, mem_we;
    logic [AW-1:0] cur_addr, mem_addr;
    logic [7:0]    mem_wdata, rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_mem [DEP];

    always #2 clk = ~clk;

    pgwr_buffer #(.AW(AW), .PW(PW), .WR_CYCLES(WR)) i_pgwr_buffer (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .addr_load(addr_load),
        .addr_in(addr_in), .data_stb(data_stb), .data_in(data_in), .bit_stb(bit_stb),
        .stop_evt(stop_evt), .wp_in(wp_in), .rd_addr(rd_addr), .busy(busy),
        .cur_addr(cur_addr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rd_data(rd_data)
    );

    // Vector: {addr[21:15], nbytes[14:10], seed[9:2], mode[1:0]}
    // mode 0 plain, 1 protect during select, 2 protect during data only.
    localparam int NV = 7;
    localparam logic [21:0] VEC [NV] = '{
        {7'h05, 5'd1,  8'hA5, 2'd0},   // R3 byte write
        {7'h12, 5'd4,  8'h10, 2'd0},   // R4 page write
        {7'h3E, 5'd5,  8'h40, 2'd0},   // R2 wrap in page
        {7'h50, 5'd18, 8'h70, 2'd0},   // R5 overflow
        {7'h20, 5'd3,  8'hC0, 2'd1},   // R8 protected
        {7'h28, 5'd2,  8'hE0, 2'd2},   // R8 late protect, R11 stale mask
        {7'h6F, 5'd16, 8'h01, 2'd0}    // R4 full page
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ev_start();
        @(negedge clk) start_evt = 1'b1;
        @(negedge clk) start_evt = 1'b0;
    endtask

    task automatic ev_addr(input logic [AW-1:0] a);
        @(negedge clk) begin addr_load = 1'b1; addr_in = a; end
        @(negedge clk) addr_load = 1'b0;
    endtask

    task automatic ev_data(input logic [7:0] d);
        @(negedge clk) begin data_stb = 1'b1; data_in = d; end
        @(negedge clk) data_stb = 1'b0;
    endtask

    task automatic ev_bit();
        @(negedge clk) bit_stb = 1'b1;
        @(negedge clk) bit_stb = 1'b0;
    endtask

    task automatic ev_stop();
        @(negedge clk) stop_evt = 1'b1;
        @(negedge clk) stop_evt = 1'b0;
    endtask

    // Count busy cycles, starting at the negedge after the stop edge.
    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < WR + 10) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_mem(input string req);
        int bad = -1;
        for (int i = 0; i < DEP; i++) begin
            rd_addr = AW'(i);
            #0.1;
            if (bad < 0 && rd_data !== exp_mem[i]) bad = i;
        end
        if (bad >= 0) begin
            rd_addr = AW'(bad);
            #0.1;
            check(1'b0, req, int'(rd_data), int'(exp_mem[bad]));
        end else begin
            check(1'b1, req, 0, 0);
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEP; i++) exp_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(cur_addr == '0, "R1 cur_addr", int'(cur_addr), 0);
        check_mem("R1 erased");

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [AW-1:0] a;
            int n, mode, blen, expb;
            logic [7:0] seed;
            logic [AW-1:0] ea;
            a    = VEC[v][21:15];
            n    = int'(VEC[v][14:10]);
            seed = VEC[v][9:2];
            mode = int'(VEC[v][1:0]);
            wp_in = (mode == 1);
            ev_start();
            wp_in = 1'b0;
            ev_addr(a);
            if (mode == 2) wp_in = 1'b1;
            for (int k = 0; k < n; k++) begin
                ev_bit();
                ev_data(seed + 8'(3 * k));
            end
            ev_stop();
            wp_in = 1'b0;
            busy_len(blen);
            expb = (mode == 1) ? 0 : WR;
            check(blen == expb, "R9 busy length", blen, expb);
            ea = a;
            ea[PW-1:0] = a[PW-1:0] + PW'(n);
            check(cur_addr == ea, "R2 cur_addr", int'(cur_addr), int'(ea));
            if (mode != 1) begin
                for (int k = 0; k < n; k++) begin
                    logic [AW-1:0] wa;
                    wa = a;
                    wa[PW-1:0] = a[PW-1:0] + PW'(k);
                    exp_mem[wa] = seed + 8'(3 * k);
                end
            end
            check_mem(mode == 1 ? "R8 protect" : "R3 R4 R5 R11 contents");
        end

        // R6: stop after a bit strobe of an unfinished byte
        ev_start(); ev_addr(7'h44); ev_data(8'h11); ev_data(8'h22); ev_bit(); ev_stop();
        check(busy == 1'b0, "R6 busy", int'(busy), 0);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R6 busy later", int'(busy), 0);
        check_mem("R6 no write");

        // R7: stop right after the address byte
        ev_start(); ev_addr(7'h48); ev_stop();
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R7 busy", int'(busy), 0);
        check_mem("R7 no write");

        // R10: events during busy are ignored
        ev_start(); ev_addr(7'h70); ev_data(8'h5A); ev_stop();
        check(busy == 1'b1, "R10 busy", int'(busy), 1);
        ev_start(); ev_addr(7'h00); ev_data(8'h99); ev_stop();
        while (busy) @(negedge clk);
        exp_mem[7'h70] = 8'h5A;
        check(cur_addr == 7'h71, "R10 R11 cur_addr", int'(cur_addr), 'h71);
        check_mem("R10 contents");
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 no new cycle", int'(busy), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule